// File: doc/BRIEF.md
# Subtraction-Based Magnitude Comparator

This block compares two N-bit operands and reports whether the first is greater than, less than, or equal to the second. Both operands go through one prefix adder. The adder computes B minus A as B plus the inverted A with a carry-in of one. The block reads the relation from flags of that one difference: the carry-out, whether the difference is zero, and its sign. It does not use a separate bitwise compare network.

A single mode input chooses the decode. Unsigned mode uses the carry-out of the subtraction. Two's-complement mode uses the difference sign, corrected for signed overflow. The block is purely combinational, so its outputs follow the inputs within the same cycle. It suits datapaths that already budget one adder delay for the compare.

Top module: `subtract_compare`

## Requirements
- R1: `a_eq_b` is 1 exactly when both operands hold the same bit pattern, in either mode.
- R2: With `signed_mode` = 0, `a_gt_b` is 1 exactly when `op_a` > `op_b` as unsigned numbers (the carry-out of B + ~A + 1 is 0).
- R3: With `signed_mode` = 0, `a_lt_b` is 1 exactly when `op_a` < `op_b` as unsigned numbers.
- R4: With `signed_mode` = 1, `a_gt_b` is 1 exactly when `op_a` > `op_b` as two's-complement numbers, bit N-1 being the sign.
- R5: With `signed_mode` = 1, `a_lt_b` is 1 exactly when `op_a` < `op_b` as two's-complement numbers.
- R6: Exactly one of `a_gt_b`, `a_lt_b`, `a_eq_b` is 1 for every input combination. `a_lt_b` is 1 when neither of the other two is.
- R7: The same bit patterns can order differently in the two modes. For example, A = 16'h8000 and B = 16'h7FFF give `a_gt_b` in unsigned mode and `a_lt_b` in signed mode.
- R8: In signed mode, pairs whose difference overflows the N-bit range still decode correctly. Examples are the most negative value against a positive value, and the most positive value against a negative value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand A |
| op_b | input | WIDTH | Second operand B |
| signed_mode | input | 1 | 1 = two's-complement compare, 0 = unsigned compare |
| a_gt_b | output | 1 | A is greater than B |
| a_lt_b | output | 1 | A is less than B |
| a_eq_b | output | 1 | A equals B |

## Verification
The hardest case to reach is a signed compare where B − A overflows. Here the raw sign of the difference is wrong and only the overflow correction gives the right answer. Uniform random pairs seldom land on the extremes of the range. The stimulus therefore drives the most negative and most positive values against each other and against small values, in both modes. It also biases part of the random pairs toward opposite signs and toward equal operands.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef enum logic {
        CMP_UNSIGNED = 1'b0,
        CMP_SIGNED   = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_rel_t;

    typedef struct packed {
        logic carry;
        logic zero;
        logic neg;
        logic ovf;
    } cmp_flags_t;

endpackage

// File: rtl/cmp_operand_prep.sv
module cmp_operand_prep #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    output logic [WIDTH-1:0] op_a_inv
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_inv
            assign op_a_inv[gi] = ~op_a[gi];
        end
    endgenerate
endmodule

// File: rtl/cmp_prefix_adder.sv
module cmp_prefix_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             c_out
);
    localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic [WIDTH-1:0] half_d;
    logic [WIDTH-1:0] grp_d;
    logic [WIDTH-1:0] carry_d;

    assign half_d = x_in ^ y_in;

    // Log-depth span doubling: after level k each bit holds the group
    // generate over up to 2^(k+1) bits below it, carry-in folded into bit 0.
    always_comb begin
        logic [WIDTH-1:0] gv, pv, gn, pn;
        gv    = x_in & y_in;
        pv    = half_d;
        gv[0] = gv[0] | (pv[0] & c_in);
        for (int k = 0; k < LEVELS; k++) begin
            for (int i = 0; i < WIDTH; i++) begin
                if (i >= (1 << k)) begin
                    gn[i] = gv[i] | (pv[i] & gv[i - (1 << k)]);
                    pn[i] = pv[i] & pv[i - (1 << k)];
                end else begin
                    gn[i] = gv[i];
                    pn[i] = pv[i];
                end
            end
            gv = gn;
            pv = pn;
        end
        grp_d = gv;
    end

    always_comb begin
        carry_d[0] = c_in;
        for (int i = 1; i < WIDTH; i++) begin
            carry_d[i] = grp_d[i-1];
        end
    end

    assign sum_out = half_d ^ carry_d;
    assign c_out   = grp_d[WIDTH-1];
endmodule

// File: rtl/cmp_rel_decode.sv
module cmp_rel_decode
    import cmp_pkg::*;
(
    input  cmp_mode_e  mode,
    input  cmp_flags_t flags,
    output cmp_rel_t   rel
);
    cmp_rel_t rel_d;

    always_comb begin
        logic sign_fix;
        sign_fix = flags.neg ^ flags.ovf;
        rel_d    = '0;
        rel_d.eq = flags.zero;
        if (mode == CMP_SIGNED) begin
            rel_d.gt = sign_fix;
        end else begin
            rel_d.gt = ~flags.carry;
        end
        rel_d.lt = ~rel_d.gt & ~rel_d.eq;
    end

    assign rel = rel_d;
endmodule

// File: rtl/subtract_compare.sv
module subtract_compare
    import cmp_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             signed_mode,
    output logic             a_gt_b,
    output logic             a_lt_b,
    output logic             a_eq_b
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] a_inv;
    logic [WIDTH-1:0] diff_d;
    logic             cout_d;
    cmp_flags_t       flags_d;
    cmp_rel_t         rel_d;
    cmp_mode_e        mode_d;

    cmp_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .op_a     (op_a),
        .op_a_inv (a_inv)
    );

    cmp_prefix_adder #(.WIDTH(WIDTH)) u_add (
        .x_in    (op_b),
        .y_in    (a_inv),
        .c_in    (1'b1),
        .sum_out (diff_d),
        .c_out   (cout_d)
    );

    always_comb begin
        mode_d        = signed_mode ? CMP_SIGNED : CMP_UNSIGNED;
        flags_d.carry = cout_d;
        flags_d.zero  = ~|diff_d;
        flags_d.neg   = diff_d[MSB];
        flags_d.ovf   = (op_a[MSB] ^ op_b[MSB]) & (diff_d[MSB] ^ op_b[MSB]);
    end

    cmp_rel_decode u_dec (
        .mode  (mode_d),
        .flags (flags_d),
        .rel   (rel_d)
    );

    assign a_gt_b = rel_d.gt;
    assign a_lt_b = rel_d.lt;
    assign a_eq_b = rel_d.eq;

    always_comb begin
        AST_ONE_RELATION: assert ($countones({rel_d.gt, rel_d.lt, rel_d.eq}) == 1); // R6
        AST_EQ_PATTERN:   assert (rel_d.eq == (op_a == op_b)); // R1
        if (!signed_mode) begin
            AST_UNS_GREATER: assert (rel_d.gt == (op_a > op_b)); // R2
            AST_UNS_LESS:    assert (rel_d.lt == (op_a < op_b)); // R3
        end else begin
            AST_SGN_GREATER: assert (rel_d.gt == ($signed(op_a) > $signed(op_b))); // R4
            AST_SGN_LESS:    assert (rel_d.lt == ($signed(op_a) < $signed(op_b))); // R5
        end
    end
endmodule

// File: tb/subtract_compare_bench.sv
module subtract_compare_bench;
    localparam int W        = 16;
    localparam int CLK_PER  = 10;
    localparam int WATCHDOG = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         signed_mode = 1'b0;
    logic         a_gt_b, a_lt_b, a_eq_b;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    localparam logic [W-1:0] MAXNEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAXPOS = {1'b0, {(W-1){1'b1}}};

    always #(CLK_PER/2) clk = ~clk;

    subtract_compare #(.WIDTH(W)) u_subtract_compare (
        .op_a        (op_a),
        .op_b        (op_b),
        .signed_mode (signed_mode),
        .a_gt_b      (a_gt_b),
        .a_lt_b      (a_lt_b),
        .a_eq_b      (a_eq_b)
    );

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic sm, input string tag);
        int  ia, ib;
        logic eg, el, ee;
        @(negedge clk);
        op_a = a; op_b = b; signed_mode = sm;
        if (sm) begin
            ia = int'($signed(a));
            ib = int'($signed(b));
        end else begin
            ia = int'({1'b0, a});
            ib = int'({1'b0, b});
        end
        eg = ia > ib; el = ia < ib; ee = ia == ib;
        #(CLK_PER/4);
        checks++;
        if ({a_gt_b, a_lt_b, a_eq_b} !== {eg, el, ee}) begin
            errors++;
            $display("FAIL %s a=%h b=%h signed=%0d got gt/lt/eq=%b%b%b exp=%b%b%b",
                     tag, a, b, sm, a_gt_b, a_lt_b, a_eq_b, eg, el, ee);
        end
        if ($countones({a_gt_b, a_lt_b, a_eq_b}) != 1) begin
            checks++;
            errors++;
            $display("FAIL R6 a=%h b=%h got gt/lt/eq=%b%b%b exp exactly one high",
                     a, b, a_gt_b, a_lt_b, a_eq_b);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Startup state: all-zero inputs read as equal (R1)
        apply('0, '0, 1'b0, "R1");
        apply('0, '0, 1'b1, "R1");
        apply(MAXPOS, MAXPOS, 1'b1, "R1");
        apply(MAXNEG, MAXNEG, 1'b0, "R1");
        // Unsigned ordering (R2, R3)
        apply(16'd5, 16'd3, 1'b0, "R2");
        apply('1, '0, 1'b0, "R2");
        apply(16'd3, 16'd5, 1'b0, "R3");
        apply('0, '1, 1'b0, "R3");
        // Signed ordering (R4, R5)
        apply(16'd1, '1, 1'b1, "R4");
        apply(16'hFFFE, 16'hFFFF, 1'b1, "R5");
        apply(16'd100, 16'd7, 1'b1, "R4");
        // Mode changes order for the same bits (R7)
        apply(MAXNEG, MAXPOS, 1'b0, "R7");
        apply(MAXNEG, MAXPOS, 1'b1, "R7");
        apply('1, 16'd1, 1'b0, "R7");
        apply('1, 16'd1, 1'b1, "R7");
        // Overflowing signed differences (R8)
        apply(MAXNEG, 16'd1, 1'b1, "R8");
        apply(MAXPOS, MAXNEG, 1'b1, "R8");
        apply(MAXPOS, '1, 1'b1, "R8");
        apply(MAXNEG, MAXPOS, 1'b1, "R8");
        apply(16'd1, MAXNEG, 1'b1, "R8");
        // Random pairs, biased part toward opposite signs and equality (R6)
        for (int n = 0; n < 2000; n++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            if (n % 4 == 1) rb = ra;
            if (n % 4 == 2) rb = {~ra[W-1], rb[W-2:0]};
            apply(ra, rb, n[0] ^ n[3], "R6");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule